// File: doc/BRIEF.md
# Reload timer with waveform output

A 16-bit up-counting timer that steps once per prescaler tick and returns to zero after it reaches a programmable reload value. A 3-bit prescaler field P divides the system clock by 4^P, so that field values 0 to 7 give divisors from 1 to 16384. The timer drives one waveform pin and has a sticky overflow flag.

The pin has two uses. The first is clock-output mode: a 50% duty-cycle square wave at the prescaled clock divided by twice the reload value. The second is output-control mode: the pin is set, cleared or toggled when the counter enters the compare value, the reload value or zero. A 2-bit action field selects the behaviour, and an output-enable bit turns on clock-output mode when the action field is zero. The run bit stops the counter in place. While the counter is stopped, some actions force a defined idle level on the pin.

Top module: `wave_timer`

## Requirements
- R1: While reset is asserted, the counter reads 0, the overflow flag is 0 and the pin is low.
- R2: While `run_en` is 1, the prescaler issues one tick every 4^P clock cycles (P = `pre_sel`), and each tick advances the counter by one. While `run_en` is 0, the counter holds its value and the prescaler phase restarts from zero.
- R3: In every mode except clock-output mode, a tick at which the counter is greater than or equal to a nonzero reload value sends the counter to 0 and sets `ovf_flag`. The flag stays set until `ovf_clr` is 1. If a new overflow and a clear arrive in the same cycle, the overflow wins.
- R4: A reload value of 0 holds the counter at 0, raises no overflow and produces no pin events.
- R5: Clock-output mode is `act_sel` = 00 with `out_en` = 1. In this mode the counter wraps on the tick at which count+1 reaches the reload value R, so one counter period is R ticks. The pin toggles at each wrap, which gives a pin period of 2·R·4^P clock cycles with a 50% duty cycle. The overflow flag is set at each wrap.
- R6: With `act_sel` = 00 and `out_en` = 0, the pin keeps its level.
- R7: With `act_sel` = 01, the pin goes low when the counter enters the compare value and high when the counter wraps to 0. If both events fall on the same tick, high wins. While `run_en` is 0, the pin is driven low.
- R8: With `act_sel` = 10, the pin goes high when the counter enters the compare value and low when the counter enters the reload value. If both events fall on the same tick, low wins. While `run_en` is 0, the pin is driven high.
- R9: With `act_sel` = 11, the pin toggles each time the counter enters the compare value. While `run_en` is 0, the pin keeps its level.
- R10: A compare or reload event fires only on the tick that moves the counter into that value. A counter held at a matching value, whether stopped or held at 0 by a zero reload, does not fire the event again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, synchronous release |
| run_en | input | 1 | Counter and prescaler run when 1 |
| out_en | input | 1 | Selects clock-output mode when `act_sel` is 00 |
| act_sel | input | 2 | Pin action: 00 none/clock-output, 01 low-on-compare, 10 high-on-compare, 11 toggle |
| pre_sel | input | 3 | Prescaler exponent P; divisor is 4^P |
| reload_val | input | 16 | Reload (top) value |
| cmp_val | input | 16 | Compare value |
| ovf_clr | input | 1 | Clears the overflow flag |
| count_q | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wave_out | output | 1 | Waveform pin |

## Verification
The bench runs each pin action with several compare and reload pairs. These include a compare value of 0 and a compare value equal to the reload value, which show whether the same-tick priorities are right. Each run contains stop intervals, which check the idle levels and the rule that an event is not repeated. Clock-output mode is measured for three combinations of reload value and prescaler. A matching pin period separates the R-tick counter cycle from an off-by-one R+1 cycle. The bench also lowers the reload value below a running count, which exercises the greater-or-equal wrap, and it sets the reload value to zero, which exercises the hold.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LO_CMP = 2'b01,
    ACT_HI_CMP = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;
endpackage

// File: rtl/wtmr_prescale.sv
module wtmr_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             tick_o
);
  localparam int DIV_W = 2 * ((1 << PRE_W) - 1);

  logic [DIV_W-1:0] ps_q, ps_d;
  logic [DIV_W:0]   lim_m1;

  always_comb begin
    lim_m1 = ({{DIV_W{1'b0}}, 1'b1} << {pre_sel, 1'b0}) - 1'b1;
    tick_o = run_en && ({1'b0, ps_q} >= lim_m1);
    if (!run_en || tick_o) ps_d = '0;
    else                   ps_d = ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (pre_sel != '0)) |=> (!tick_o || (pre_sel == '0))); // R2
endmodule

// File: rtl/wtmr_count.sv
module wtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clk_mode_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic             ev_cmp_o,
  output logic             ev_rld_o,
  output logic             ev_wrap_o
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   inc;
  logic             ovf_d, moved;

  always_comb begin
    inc       = {1'b0, cnt_q} + 1'b1;
    cnt_d     = cnt_q;
    ev_wrap_o = 1'b0;
    if (tick_i && (reload_i != '0)) begin
      if (clk_mode_i ? (inc >= {1'b0, reload_i}) : (cnt_q >= reload_i)) begin
        cnt_d     = '0;
        ev_wrap_o = 1'b1;
      end else begin
        cnt_d = inc[CNT_W-1:0];
      end
    end
    moved    = (cnt_d != cnt_q);
    ev_cmp_o = moved && (cnt_d == cmp_i);
    ev_rld_o = moved && (cnt_d == reload_i);
    if (ev_wrap_o)      ovf_d = 1'b1;
    else if (ovf_clr_i) ovf_d = 1'b0;
    else                ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap_o |=> (cnt_q == '0 && ovf_q)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q); // R3
  AST_ZERO_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i == '0 && cnt_q == '0) |=> (cnt_q == '0)); // R4
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/wtmr_wave.sv
module wtmr_wave
  import wtmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic out_en,
  input  act_e act_i,
  input  logic ev_cmp_i,
  input  logic ev_rld_i,
  input  logic ev_wrap_i,
  output logic pin_q
);
  logic pin_d;

  always_comb begin
    pin_d = pin_q;
    unique case (act_i)
      ACT_NONE: begin
        if (out_en && ev_wrap_i) pin_d = ~pin_q;
      end
      ACT_LO_CMP: begin
        if (!run_en)        pin_d = 1'b0;
        else if (ev_wrap_i) pin_d = 1'b1;
        else if (ev_cmp_i)  pin_d = 1'b0;
      end
      ACT_HI_CMP: begin
        if (!run_en)       pin_d = 1'b1;
        else if (ev_rld_i) pin_d = 1'b0;
        else if (ev_cmp_i) pin_d = 1'b1;
      end
      ACT_TOGGLE: begin
        if (ev_cmp_i) pin_d = ~pin_q;
      end
      default: pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_LO_CMP && !run_en) |=> !pin_q); // R7
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_HI_CMP && !run_en) |=> pin_q); // R8
  AST_PIN_KEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_NONE && !out_en) |=> $stable(pin_q)); // R6
  AST_TOGGLE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_TOGGLE && !run_en) |=> $stable(pin_q)); // R9
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             out_en,
  input  logic [1:0]       act_sel,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_flag,
  output logic             wave_out
);
  act_e act;
  logic tick, clk_mode, ev_cmp, ev_rld, ev_wrap;

  always_comb begin
    act      = act_e'(act_sel);
    clk_mode = (act == ACT_NONE) && out_en;
  end

  wtmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pre_sel(pre_sel), .tick_o(tick)
  );

  wtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .clk_mode_i(clk_mode),
    .reload_i(reload_val), .cmp_i(cmp_val), .ovf_clr_i(ovf_clr),
    .cnt_q(count_q), .ovf_q(ovf_flag),
    .ev_cmp_o(ev_cmp), .ev_rld_o(ev_rld), .ev_wrap_o(ev_wrap)
  );

  wtmr_wave u_wave (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .out_en(out_en), .act_i(act),
    .ev_cmp_i(ev_cmp), .ev_rld_i(ev_rld), .ev_wrap_i(ev_wrap), .pin_q(wave_out)
  );

  AST_RUN_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(count_q)); // R2
endmodule

// File: tb/wave_timer_bench.sv
module wave_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, run_en, out_en, ovf_clr;
  logic [1:0]  act_sel;
  logic [2:0]  pre_sel;
  logic [15:0] reload_val, cmp_val, count_q;
  logic        ovf_flag, wave_out;

  int compared = 0, mismatched = 0;
  bit done = 0;
  int m_cnt, m_ps, m_ovf, m_pin;

  always #5 clk = ~clk;

  wave_timer u_wave_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .out_en(out_en), .act_sel(act_sel),
    .pre_sel(pre_sel), .reload_val(reload_val), .cmp_val(cmp_val), .ovf_clr(ovf_clr),
    .count_q(count_q), .ovf_flag(ovf_flag), .wave_out(wave_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string pin_tag();
    case (act_sel)
      2'b00:   return out_en ? "R5 pin" : "R6 pin";
      2'b01:   return "R7 pin";
      2'b10:   return "R8 pin";
      default: return "R9 pin";
    endcase
  endfunction

  // Behavioural reference model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ps = 0; m_ovf = 0; m_pin = 0;
    end else begin
      int lim, r, c, old;
      bit tk, wrap, clkm, moved, hc, hr;
      lim = 1 << (2 * int'(pre_sel));
      tk = 0;
      if (!run_en) m_ps = 0;
      else if (m_ps + 1 >= lim) begin tk = 1; m_ps = 0; end
      else m_ps = m_ps + 1;
      r = int'(reload_val); c = int'(cmp_val); old = m_cnt; wrap = 0;
      clkm = (act_sel == 2'b00) && out_en;
      if (tk && r != 0) begin
        if (clkm ? (m_cnt + 1 >= r) : (m_cnt >= r)) begin m_cnt = 0; wrap = 1; end
        else m_cnt = m_cnt + 1;
      end
      moved = (m_cnt != old);
      hc = moved && (m_cnt == c);
      hr = moved && (m_cnt == r);
      case (act_sel)
        2'b00: if (out_en && wrap) m_pin = 1 - m_pin;
        2'b01: if (!run_en) m_pin = 0; else if (wrap) m_pin = 1; else if (hc) m_pin = 0;
        2'b10: if (!run_en) m_pin = 1; else if (hr) m_pin = 0; else if (hc) m_pin = 1;
        default: if (hc) m_pin = 1 - m_pin;
      endcase
      if (wrap) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 count", int'(count_q), m_cnt);
      check("R3 ovf", int'(ovf_flag), m_ovf);
      check(pin_tag(), int'(wave_out), m_pin);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int exp);
    logic p;
    int n;
    for (int k = 0; k < 3; k++) begin
      p = wave_out; n = 0;
      while (wave_out == p && n < 2000) begin @(negedge clk); n++; end
      if (k > 0) check("R5 half period", n, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    logic p0;
    int n;
    rst_n = 0; run_en = 0; out_en = 0; ovf_clr = 0; act_sel = 2'b00;
    pre_sel = 0; reload_val = 0; cmp_val = 0;
    cycles(3);
    check("R1 count", int'(count_q), 0);
    check("R1 ovf", int'(ovf_flag), 0);
    check("R1 pin", int'(wave_out), 0);
    rst_n = 1;

    // R7: low on compare, high at wrap
    act_sel = 2'b01; reload_val = 9; cmp_val = 4; run_en = 1;
    cycles(60);
    run_en = 0; cycles(5);
    check("R7 idle low", int'(wave_out), 0);
    run_en = 1; cmp_val = 0; reload_val = 5; cycles(40);

    // R8: high on compare, low on reload
    act_sel = 2'b10; pre_sel = 1; reload_val = 6; cmp_val = 2; cycles(120);
    run_en = 0; cycles(10);
    check("R8 idle high", int'(wave_out), 1);
    run_en = 1; cmp_val = 6; cycles(80);

    // R9 and R10: toggle on compare, no repeat while held at compare
    act_sel = 2'b11; pre_sel = 0; reload_val = 7; cmp_val = 3; cycles(50);
    n = 0;
    while (count_q != 16'd3 && n < 100) begin @(negedge clk); n++; end
    run_en = 0; p0 = wave_out; cycles(10);
    check("R10 held at compare", int'(wave_out), int'(p0));
    run_en = 1; cycles(1);
    check("R10 leave compare", int'(wave_out), int'(p0));
    check("R2 resume step", int'(count_q), 4);

    // R5: clock output
    act_sel = 2'b00; out_en = 1; reload_val = 5; pre_sel = 0; cycles(10);
    measure(5);
    reload_val = 3; pre_sel = 1; cycles(30);
    measure(12);
    reload_val = 1; pre_sel = 0; cycles(4);
    measure(1);

    // R6: no action, output disabled
    out_en = 0; reload_val = 4; p0 = wave_out; cycles(40);
    check("R6 pin kept", int'(wave_out), int'(p0));

    // R4: zero reload holds counter
    act_sel = 2'b01; reload_val = 0; cycles(3); ovf_clr = 1; cycles(1); ovf_clr = 0; cycles(30);
    check("R4 count held", int'(count_q), 0);
    check("R4 no ovf", int'(ovf_flag), 0);

    // R3: clear, then lowered reload below count
    reload_val = 50; cmp_val = 20;
    n = 0;
    while (count_q != 16'd30 && n < 200) begin @(negedge clk); n++; end
    reload_val = 10; cycles(2);
    check("R3 ge wrap", int'(count_q), 1);
    check("R3 ovf set", int'(ovf_flag), 1);
    run_en = 0; ovf_clr = 1; cycles(1); ovf_clr = 0;
    check("R3 ovf cleared", int'(ovf_flag), 0);
    run_en = 1; cycles(40);

    done = 1;
    summary();
    $finish;
  end
endmodule